// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a watchdog that software controls through a single 32-bit control and status word. Two small encoded fields set the timeout. One is a prescale code that sets how many base ticks make one counting step. The other is an interval code that sets how many steps make one timeout. When a timeout elapses, the block can raise a sticky warning flag and an interrupt. After a fixed grace period it then emits a system reset pulse and records a sticky reset flag. Software keeps the system alive by writing the word back with the restart bit set. That bit is never stored, so it always reads back as zero.

A timeout lasts `TICK_CYC * 2^s * IVL_BASE * 4^ivl` clock cycles. Here `s` is 0, 3, 6 or 11 for prescale codes 0 to 3. As a result, code 2 is eight times code 1, and code 3 is thirty-two times code 2. When the reset pulse starts, the block clears its own control fields as the rest of the chip would on a reset. The reset flag stays set, so software can tell after the restart that the watchdog caused it.

Top module: `wdg_timer`

## Requirements
- R1: A write stores prescale code in bits 11:10, run enable in bit 7, interrupt enable in bit 6, interval code in bits 5:4 and reset enable in bit 1; bit 0 (restart) always reads 0 and all other unlisted bits read 0.
- R2: After the `rst` input, the word reads 0 and both `irq` and `sys_rst` are low.
- R3: With run enable set, the timeout ends exactly `TICK_CYC * 2^s * IVL_BASE * 4^ivl` cycles after the enabling write, with s = 0, 3, 6, 11 for prescale codes 0..3.
- R4: While run enable (bit 7) is 0, nothing counts: no warning and no reset occur however long the block waits.
- R5: A write with bit 0 set starts the timeout over from zero.
- R6: A write that changes the prescale or interval code starts the timeout over, even without bit 0.
- R7: When a timeout ends with interrupt enable set, the warning flag (bit 3) is set and `irq` (warning flag AND interrupt enable) goes high.
- R8: With interrupt enable set, the reset pulse starts `GRACE_TICKS` prescaled steps after the warning if reset enable is set; otherwise no reset follows.
- R9: With interrupt enable clear and reset enable set, the reset pulse starts at the end of the timeout and the warning flag stays 0.
- R10: The reset pulse lasts exactly `RST_PULSE` cycles; when it starts, every control field and the warning flag clear and the reset flag (bit 2) is set.
- R11: Both flags are sticky and are cleared by writing 1 to their own bit; the reset flag survives the block's own reset pulse and is cleared by the `rst` input.
- R12: No reset pulse starts in any cycle in which reset enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data written to the control word |
| rd_data | output | 32 | Current control and status word |
| irq | output | 1 | Early-warning interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with `TICK_CYC=2`, `IVL_BASE=4`, `GRACE_TICKS=3` and `RST_PULSE=5`. With these values the shortest timeout is 8 cycles and the grace period is 6 cycles at prescale code 0. Prescale code 3 with interval code 0 takes 16384 cycles. Every prescale code, the full interval range at codes 0 and 1, and the exact edge of each warning and reset fit well inside one run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Bit positions inside the control/status word.
    localparam int DIV_LSB  = 10;
    localparam int RUN_BIT  = 7;
    localparam int IEN_BIT  = 6;
    localparam int IVL_LSB  = 4;
    localparam int WARN_BIT = 3;
    localparam int RFLG_BIT = 2;
    localparam int REN_BIT  = 1;
    localparam int KICK_BIT = 0;

    typedef struct packed {
        logic [1:0] div;
        logic       run;
        logic       irq_en;
        logic [1:0] ivl;
        logic       warn;
        logic       rflag;
        logic       rst_en;
    } ctrl_t;

    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_GRACE = 1'b1
    } phase_e;

    // log2 of the prescale ratio per code.
    function automatic logic [3:0] div_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd0;
            2'd1:    return 4'd3;
            2'd2:    return 4'd6;
            default: return 4'd11;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[DIV_LSB +: 2] = c.div;
        w[RUN_BIT]      = c.run;
        w[IEN_BIT]      = c.irq_en;
        w[IVL_LSB +: 2] = c.ivl;
        w[WARN_BIT]     = c.warn;
        w[RFLG_BIT]     = c.rflag;
        w[REN_BIT]      = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int TICK_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div,
    output logic       tick
);
    import wdg_pkg::*;

    logic        base_tick;
    logic [10:0] dcnt;
    logic [10:0] dmax;

    generate
        if (TICK_CYC == 1) begin : g_direct
            assign base_tick = run;
        end else begin : g_count
            localparam int PW = $clog2(TICK_CYC);
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst || !run)                   pcnt <= '0;
                else if (pcnt == PW'(TICK_CYC - 1)) pcnt <= '0;
                else                                pcnt <= pcnt + 1'b1;
            end
            assign base_tick = run && (pcnt == PW'(TICK_CYC - 1));
        end
    endgenerate

    assign dmax = 11'((12'd1 << div_shift(div)) - 12'd1);

    always_ff @(posedge clk) begin
        if (rst || !run)     dcnt <= '0;
        else if (base_tick)  dcnt <= (dcnt == dmax) ? '0 : dcnt + 1'b1;
    end

    assign tick = base_tick && (dcnt == dmax);

endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry #(
    parameter int IVL_BASE    = 1024,
    parameter int GRACE_TICKS = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] ivl,
    input  logic       irq_en,
    input  logic       rst_en,
    output logic       warn,
    output logic       fire
);
    import wdg_pkg::*;

    localparam int IW = $clog2(IVL_BASE * 64 + 1);
    localparam int GW = $clog2(GRACE_TICKS + 1);

    phase_e        phase;
    logic [IW-1:0] icnt;
    logic [IW-1:0] ilim;
    logic [GW-1:0] gcnt;
    logic          ivl_done;
    logic          grace_done;

    assign ilim       = IW'(IVL_BASE) << {ivl, 1'b0};
    assign ivl_done   = tick && (phase == PH_COUNT) && (icnt == ilim - IW'(1));
    assign grace_done = tick && (phase == PH_GRACE) && (gcnt == GW'(GRACE_TICKS - 1));
    assign warn       = ivl_done && irq_en;
    assign fire       = rst_en && ((ivl_done && !irq_en) || grace_done);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_COUNT;
            icnt  <= '0;
            gcnt  <= '0;
        end else if (phase == PH_COUNT) begin
            if (ivl_done) begin
                icnt <= '0;
                gcnt <= '0;
                if (irq_en) phase <= PH_GRACE;
            end else if (tick) begin
                icnt <= icnt + 1'b1;
            end
        end else begin
            if (grace_done) begin
                phase <= PH_COUNT;
                gcnt  <= '0;
            end else if (tick) begin
                gcnt <= gcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int RST_PULSE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int RW = $clog2(RST_PULSE + 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (fire)       cnt <= RW'(RST_PULSE);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int TICK_CYC    = 25000,
    parameter int IVL_BASE    = 1024,
    parameter int GRACE_TICKS = 1024,
    parameter int RST_PULSE   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        sys_rst
);
    import wdg_pkg::*;

    ctrl_t      ctrl;
    logic [1:0] w_div;
    logic [1:0] w_ivl;
    logic       restart;
    logic       run;
    logic       tick;
    logic       warn;
    logic       fire;
    logic       unused_bits;

    assign w_div   = wr_data[DIV_LSB +: 2];
    assign w_ivl   = wr_data[IVL_LSB +: 2];
    assign restart = wr_en && (wr_data[KICK_BIT] || (w_div != ctrl.div) || (w_ivl != ctrl.ivl));
    assign run     = ctrl.run && !restart;
    assign unused_bits = ^{wr_data[31:12], wr_data[9:8]};

    wdg_prescaler #(.TICK_CYC(TICK_CYC)) i_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (ctrl.div),
        .tick (tick)
    );

    wdg_expiry #(.IVL_BASE(IVL_BASE), .GRACE_TICKS(GRACE_TICKS)) i_exp (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .ivl    (ctrl.ivl),
        .irq_en (ctrl.irq_en),
        .rst_en (ctrl.rst_en),
        .warn   (warn),
        .fire   (fire)
    );

    wdg_pulse #(.RST_PULSE(RST_PULSE)) i_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (sys_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (fire) begin
            ctrl       <= '0;
            ctrl.rflag <= 1'b1;
        end else begin
            if (wr_en) begin
                ctrl.div    <= w_div;
                ctrl.run    <= wr_data[RUN_BIT];
                ctrl.irq_en <= wr_data[IEN_BIT];
                ctrl.ivl    <= w_ivl;
                ctrl.rst_en <= wr_data[REN_BIT];
                ctrl.warn   <= ctrl.warn  & ~wr_data[WARN_BIT];
                ctrl.rflag  <= ctrl.rflag & ~wr_data[RFLG_BIT];
            end
            if (warn) ctrl.warn <= 1'b1;
        end
    end

    assign rd_data = ctrl_to_word(ctrl);
    assign irq     = ctrl.warn && ctrl.irq_en;

endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
    parameter int RST_PULSE = 16
) (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic wr_clr_warn,
    input logic wr_clr_rflag,
    input logic st_run,
    input logic st_warn,
    input logic st_rflag,
    input logic st_rst_en,
    input logic sys_rst
);
    localparam int HW = $clog2(RST_PULSE + 2);

    logic [HW-1:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)          hi_len <= '0;
        else if (sys_rst) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> hi_len == HW'(RST_PULSE)); // R10

    AST_PULSE_CLEARS_CTRL: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> (st_rflag && !st_run && !st_rst_en && !st_warn)); // R10

    AST_NO_RESET_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !st_rst_en |=> !$rose(sys_rst)); // R12

    AST_RFLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_rflag && !(wr_en && wr_clr_rflag)) |=> st_rflag); // R11

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_warn && !(wr_en && wr_clr_warn)) |=> (st_warn || $rose(sys_rst))); // R11

endmodule

bind wdg_timer wdg_timer_chk #(.RST_PULSE(RST_PULSE)) i_wdg_timer_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_clr_warn  (wr_data[3]),
    .wr_clr_rflag (wr_data[2]),
    .st_run       (rd_data[7]),
    .st_warn      (rd_data[3]),
    .st_rflag     (rd_data[2]),
    .st_rst_en    (rd_data[1]),
    .sys_rst      (sys_rst)
);

// File: tb/test_wdg_timer.sv
`timescale 1ns/1ps
module test_wdg_timer;

    localparam int TICK  = 2;
    localparam int IBASE = 4;
    localparam int GRACE = 3;
    localparam int PLEN  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        sys_rst;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdg_timer #(.TICK_CYC(TICK), .IVL_BASE(IBASE), .GRACE_TICKS(GRACE), .RST_PULSE(PLEN)) i_wdg_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
    );

    function automatic int sh(input int d);
        case (d)
            0: return 0;
            1: return 3;
            2: return 6;
            default: return 11;
        endcase
    endfunction

    function automatic int exp_to(input int d, input int v);
        return TICK * (1 << sh(d)) * IBASE * (1 << (2 * v));
    endfunction

    function automatic int exp_gr(input int d);
        return TICK * (1 << sh(d)) * GRACE;
    endfunction

    function automatic logic [31:0] cw(input int d, input int en, input int ie,
                                       input int v, input int re, input int kick);
        return (32'(d) << 10) | (32'(en) << 7) | (32'(ie) << 6) |
               (32'(v) << 4) | (32'(re) << 1) | 32'(kick);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Counts edges since the last write; records first irq and reset edges.
    task automatic run_until(input int limit, output int t_irq, output int t_rst, output int plen);
        bit seen;
        t_irq = -1; t_rst = -1; plen = 0; seen = 1'b0;
        for (int n = 1; n <= limit && !seen; n++) begin
            @(negedge clk);
            if (irq && t_irq < 0) t_irq = n;
            if (sys_rst) begin
                t_rst = n;
                plen  = 1;
                seen  = 1'b1;
                @(negedge clk);
                while (sys_rst) begin
                    plen++;
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ti, tr, pl;
        void'($urandom(32'd77));
        do_reset();

        // R2 reset state
        chk(rd_data == 32'h0 && !irq && !sys_rst, "R2 reset state", rd_data, 0);

        // R1 field layout and readback
        wr(32'hFFFF_FF7F);
        chk(rd_data == 32'h0000_0C72, "R1 readback", rd_data, 32'hC72);

        // R4 disabled: nothing happens
        run_until(200, ti, tr, pl);
        chk(ti == -1, "R4 no irq while disabled", ti, -1);
        chk(tr == -1, "R4 no reset while disabled", tr, -1);
        wr(32'h0);

        // R3 R7 warning at timeout, R12 no reset with reset enable clear
        wr(cw(0, 1, 1, 0, 0, 1));
        run_until(exp_to(0, 0) + exp_gr(0) + 30, ti, tr, pl);
        chk(ti == exp_to(0, 0), "R7 irq edge", ti, exp_to(0, 0));
        chk(rd_data[3] == 1'b1, "R7 warn flag set", rd_data[3], 1);
        chk(tr == -1, "R12 no reset when unarmed", tr, -1);
        wr(32'h0000_0008);
        chk(rd_data == 32'h0, "R11 warn flag cleared by write-one", rd_data, 0);

        // R8 R10 reset after grace
        wr(cw(0, 1, 1, 0, 1, 1));
        run_until(100, ti, tr, pl);
        chk(ti == exp_to(0, 0), "R8 irq before reset", ti, exp_to(0, 0));
        chk(tr == exp_to(0, 0) + exp_gr(0), "R8 reset after grace", tr, exp_to(0, 0) + exp_gr(0));
        chk(pl == PLEN, "R10 pulse length", pl, PLEN);
        chk(rd_data == 32'h0000_0004 && !irq, "R10 control cleared, reset flag set", rd_data, 4);

        // R11 reset flag cleared by power-on reset
        do_reset();
        chk(rd_data == 32'h0, "R11 reset flag cleared by rst", rd_data, 0);

        // R9 direct reset without warning
        wr(cw(0, 1, 0, 0, 1, 1));
        run_until(100, ti, tr, pl);
        chk(tr == exp_to(0, 0), "R9 direct reset edge", tr, exp_to(0, 0));
        chk(ti == -1, "R9 no irq", ti, -1);
        chk(rd_data == 32'h0000_0004, "R9 warn flag stays clear", rd_data, 4);
        wr(32'h0000_0004);
        chk(rd_data == 32'h0, "R11 reset flag cleared by write-one", rd_data, 0);

        // R5 keepalive restarts the count
        wr(cw(0, 1, 1, 1, 0, 1));
        run_until(20, ti, tr, pl);
        chk(ti == -1, "R5 no early irq", ti, -1);
        wr(cw(0, 1, 1, 1, 0, 1));
        run_until(60, ti, tr, pl);
        chk(ti == exp_to(0, 1), "R5 irq after keepalive", ti, exp_to(0, 1));
        wr(32'h0000_0008);

        // R6 changing the interval code restarts the count
        wr(cw(0, 1, 1, 1, 0, 1));
        run_until(20, ti, tr, pl);
        wr(cw(0, 1, 1, 0, 0, 0));
        run_until(40, ti, tr, pl);
        chk(ti == exp_to(0, 0), "R6 restart on code change", ti, exp_to(0, 0));
        wr(32'h0000_0008);

        // R3 slowest prescale code
        wr(cw(3, 1, 0, 0, 1, 1));
        run_until(exp_to(3, 0) + 50, ti, tr, pl);
        chk(tr == exp_to(3, 0), "R3 prescale code 3 timeout", tr, exp_to(3, 0));
        wr(32'h0000_0004);

        // Random trials R3 R7 R8 R9
        for (int k = 0; k < 10; k++) begin
            int d, v, ie, re, t, g, ei, er;
            d  = int'($urandom % 3);
            v  = (d == 2) ? int'($urandom % 2) : int'($urandom % 4);
            ie = int'($urandom % 2);
            re = ie ? int'($urandom % 2) : 1;
            t  = exp_to(d, v);
            g  = exp_gr(d);
            ei = ie ? t : -1;
            er = re ? (ie ? t + g : t) : -1;
            wr(cw(d, 1, ie, v, re, 1));
            run_until(t + g + 40, ti, tr, pl);
            chk(ti == ei, "R3 R7 random irq edge", ti, ei);
            chk(tr == er, "R8 R9 random reset edge", tr, er);
            wr(32'h0000_000C);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule